// File: doc/BRIEF.md
# Prescaled Timer/Counter with Two Compare Channels

This block is a general-purpose timer/counter for a small embedded subsystem. A free-running prescaler divides the system clock by a selectable ratio, and each prescaler tick advances a counter. The counter can count up and wrap, clear on a match with compare channel A, clear at a programmed top value, or run as an up/down (phase-correct) counter. Two compare channels raise match flags. An overflow event raises a third flag. Each flag is cleared by writing one to it, and a mask register routes each flag to its own interrupt request line, which goes to an external interrupt controller.

Software reaches the block through a byte-wide register port. When `WIDTH` is above 8, a 16-bit register is written by storing the high byte in a shared temporary byte first; the following low-byte write then commits both bytes at once. Reading the counter's low byte copies the counter's high byte into the same temporary byte, so a later high-byte read returns a value consistent with that low byte. The current count is also driven out directly for compare or waveform logic elsewhere.

Top module: `cmp_timer`

## Requirements
- R1: Register addresses: 0 control (bits 2:0 clock select, bits 5:3 count mode), 1/2 counter low/high, 3/4 compare A low/high, 5/6 compare B low/high, 7 flags, 8 interrupt mask, 9/10 top low/high. Flag and mask bits: 0 overflow, 1 compare A, 2 compare B. After reset every register and the counter are 0 and no request is raised.
- R2: A clock select of 0 stops the counter.
- R3: Standard divider table (`ALT_DIV`=0): select 1 gives /1, 2 gives /8, 3 gives /64, 4 gives /256, 5 gives /1024, 6 and 7 stop. Alternate table (`ALT_DIV`=1): 1 gives /1, 2 gives /8, 3 gives /32, 4 gives /64, 5 gives /128, 6 gives /256, 7 gives /1024.
- R4: A control write restarts the prescaler. With a ratio of N, the counter first advances on the N-th clock edge after the write edge and then every N edges. With /256 it reads 0 after 255 edges, 1 after 256 and 511 edges, and 2 after 512 edges.
- R5: In mode 0 (normal) and mode 2 (fast PWM), a step from all-ones to 0 sets the overflow flag.
- R6: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. Each request output is its flag ANDed with the matching mask bit, so clearing a flag drops its request.
- R7: When the counter steps to a nonzero value equal to compare A, the compare-A flag is set. A step to a nonzero value equal to compare B sets the compare-B flag.
- R8: In mode 1 (clear on compare A), a compare-A match puts the counter at 0 in place of the matched value and also sets the overflow flag.
- R9: A compare register that holds 0 never produces a match.
- R10: In mode 3 (phase-correct), the counter counts up to all-ones and then counts down. Reaching 0 while counting down sets the overflow flag, and counting then resumes upward.
- R11: For `WIDTH` above 8, a high-byte write only loads the temporary byte. The next low-byte write commits the temporary byte and the low byte together.
- R12: For `WIDTH` above 8, a read of counter low (address 1) copies the counter's high byte into the temporary byte, and a read of counter high (address 2) returns the temporary byte.
- R13: In mode 4 (clear at top register), the counter goes to 0 on the step after it has reached the top value, and no overflow flag is set.
- R14: A counter write takes priority over a prescaler step in the same cycle, and that cycle produces no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the low-byte copy side effect) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| count_o | output | WIDTH | Current counter value |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |

## Verification
The in-RTL properties check on every cycle that:
- a stopped clock select produces no tick;
- a zero compare register never matches;
- a clear-on-A match and a phase-correct overflow leave the counter at 0;
- the top-register mode never sets overflow;
- a software counter write lands unchanged;
- a flag written with one is clear on the next cycle.

Only the directed scenarios can show the absolute timing of the divider ratios, the exact wrap and turn-around points of each mode, and the ordering of the temporary-byte protocol across separate bus accesses. The high byte latched on a low-byte read staying stable across a carry also needs a scenario.

// File: rtl/cmp_timer_pkg.sv
// Package: shared encodings for the prescaled compare timer.
// Assumes a 4-bit register address space and an 8-bit data port.
package cmp_timer_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL   = 3'd0,
        MODE_CTC_A    = 3'd1,
        MODE_FAST_PWM = 3'd2,
        MODE_PHASE    = 3'd3,
        MODE_CTC_TOP  = 3'd4
    } count_mode_e;

    localparam logic [3:0] ADR_CTRL   = 4'd0;
    localparam logic [3:0] ADR_CNT_L  = 4'd1;
    localparam logic [3:0] ADR_CNT_H  = 4'd2;
    localparam logic [3:0] ADR_CMPA_L = 4'd3;
    localparam logic [3:0] ADR_CMPA_H = 4'd4;
    localparam logic [3:0] ADR_CMPB_L = 4'd5;
    localparam logic [3:0] ADR_CMPB_H = 4'd6;
    localparam logic [3:0] ADR_FLAG   = 4'd7;
    localparam logic [3:0] ADR_MASK   = 4'd8;
    localparam logic [3:0] ADR_TOP_L  = 4'd9;
    localparam logic [3:0] ADR_TOP_H  = 4'd10;

    // Standard divider table; 0 means stopped.
    function automatic logic [31:0] std_ratio(input logic [2:0] sel);
        case (sel)
            3'd1:    return 32'd1;
            3'd2:    return 32'd8;
            3'd3:    return 32'd64;
            3'd4:    return 32'd256;
            3'd5:    return 32'd1024;
            default: return 32'd0;
        endcase
    endfunction

    // Alternate divider table with finer steps; 0 means stopped.
    function automatic logic [31:0] alt_ratio(input logic [2:0] sel);
        case (sel)
            3'd1:    return 32'd1;
            3'd2:    return 32'd8;
            3'd3:    return 32'd32;
            3'd4:    return 32'd64;
            3'd5:    return 32'd128;
            3'd6:    return 32'd256;
            3'd7:    return 32'd1024;
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/timer_prescale.sv
// Prescaler: emits a one-cycle tick every N clocks for the selected ratio.
// Assumes the ratio never exceeds MAX_RATIO; restart clears the phase.
module timer_prescale
    import cmp_timer_pkg::*;
#(
    parameter bit ALT_DIV   = 1'b0,
    parameter int MAX_RATIO = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam int PSC_W = $clog2(MAX_RATIO);

    logic [PSC_W-1:0] psc_q;
    logic [31:0]      ratio;

    // Pick the divider table variant.
    generate
        if (ALT_DIV) begin : g_alt
            assign ratio = alt_ratio(sel);
        end else begin : g_std
            assign ratio = std_ratio(sel);
        end
    endgenerate

    // Tick on the last phase count of the selected ratio.
    always_comb begin
        tick = (ratio != 32'd0) && ({{(32-PSC_W){1'b0}}, psc_q} == ratio - 32'd1);
    end

    // Advance the phase counter; restart, stop and tick clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || ratio == 32'd0 || tick) begin
            psc_q <= '0;
        end else begin
            psc_q <= psc_q + 1'b1;
        end
    end

    // R2: stopped select never ticks
    p_stopped_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd0) |-> !tick);

endmodule

// File: rtl/timer_core.sv
// Counter core: steps the count per tick according to the mode and
// reports overflow and compare events. Assumes load and tick may coincide.
module timer_core
    import cmp_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  count_mode_e      mode,
    input  logic [WIDTH-1:0] cmp_a,
    input  logic [WIDTH-1:0] cmp_b,
    input  logic [WIDTH-1:0] top_val,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] cnt,
    output logic             set_ovf,
    output logic             set_cmpa,
    output logic             set_cmpb
);
    localparam logic [WIDTH-1:0] CNT_MAX = '1;
    localparam logic [WIDTH-1:0] CNT_ONE = 1;

    logic [WIDTH-1:0] cnt_q, stepped;
    logic             dir_up_q, dir_d, wrap_ovf, advance, hit_a, hit_b, clear_ctc;

    // Next count, direction and wrap event for the current mode.
    always_comb begin
        stepped  = cnt_q + CNT_ONE;
        wrap_ovf = 1'b0;
        dir_d    = 1'b1;
        case (mode)
            MODE_NORMAL, MODE_FAST_PWM: wrap_ovf = (cnt_q == CNT_MAX);
            MODE_PHASE: begin
                if (dir_up_q) begin
                    if (cnt_q == CNT_MAX) begin
                        stepped = cnt_q - CNT_ONE;
                        dir_d   = 1'b0;
                    end else begin
                        dir_d = (cnt_q != CNT_MAX - CNT_ONE);
                    end
                end else if (cnt_q == '0) begin
                    stepped = CNT_ONE;
                end else begin
                    stepped  = cnt_q - CNT_ONE;
                    wrap_ovf = (cnt_q == CNT_ONE);
                    dir_d    = (cnt_q == CNT_ONE);
                end
            end
            MODE_CTC_TOP: stepped = (cnt_q >= top_val) ? '0 : cnt_q + CNT_ONE;
            default: ;
        endcase
    end

    // Compare matches on the stepped value; a pending load suppresses events.
    always_comb begin
        advance   = tick && !load;
        hit_a     = advance && (cmp_a != '0) && (stepped == cmp_a);
        hit_b     = advance && (cmp_b != '0) && (stepped == cmp_b);
        clear_ctc = hit_a && (mode == MODE_CTC_A);
        set_ovf   = advance && (wrap_ovf || clear_ctc);
        set_cmpa  = hit_a;
        set_cmpb  = hit_b;
    end

    // Counter register: software load first, then the tick step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            dir_up_q <= 1'b1;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q    <= clear_ctc ? '0 : stepped;
            dir_up_q <= dir_d;
        end
    end

    assign cnt = cnt_q;

    // R5: wrap overflow in normal / fast PWM lands on zero
    p_wrap_lands_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ovf && (mode == MODE_NORMAL || mode == MODE_FAST_PWM)) |=> (cnt_q == '0));
    // R8: compare-A match in clear-on-A mode returns to zero
    p_ctc_returns_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cmpa && mode == MODE_CTC_A) |=> (cnt_q == '0));
    // R9: zero compare registers never match
    p_zero_no_match_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_a == '0) |-> !set_cmpa);
    p_zero_no_match_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_b == '0) |-> !set_cmpb);
    // R10: phase-correct overflow only at the bottom
    p_phase_ovf_bottom_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ovf && mode == MODE_PHASE) |=> (cnt_q == '0));
    // R13: top-register mode never flags overflow
    p_top_mode_no_ovf_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CTC_TOP) |-> !set_ovf);
    // R14: software write lands unchanged
    p_load_wins_r14: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/timer_regs.sv
// Register file: control, compare, top, mask and flag registers plus the
// shared temporary high byte for atomic wide access. Assumes WIDTH 8..16.
module timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [3:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [WIDTH-1:0] cnt,
    input  logic             set_ovf,
    input  logic             set_cmpa,
    input  logic             set_cmpb,
    output logic [2:0]       clk_sel,
    output count_mode_e      mode,
    output logic             ctrl_wr,
    output logic             load,
    output logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] cmp_a,
    output logic [WIDTH-1:0] cmp_b,
    output logic [WIDTH-1:0] top_val,
    output logic [2:0]       irq_vec
);
    logic [5:0]       ctrl_q;
    logic [WIDTH-1:0] cmp_a_q, cmp_b_q, top_q;
    logic [2:0]       mask_q, flag_q, flag_clr, flag_set;
    logic [7:0]       temp_q, cnt_hi_rd;
    logic [15:0]      wide16, cnt16, cmpa16, cmpb16, top16;
    logic [WIDTH-1:0] wide_val;
    logic             hi_wr;

    // Wide write value and zero-extended views for byte reads.
    always_comb begin
        wide16   = {temp_q, wdata};
        wide_val = wide16[WIDTH-1:0];
        cnt16    = 16'(cnt);
        cmpa16   = 16'(cmp_a_q);
        cmpb16   = 16'(cmp_b_q);
        top16    = 16'(top_q);
        hi_wr    = wr_en && (addr == ADR_CNT_H || addr == ADR_CMPA_H ||
                             addr == ADR_CMPB_H || addr == ADR_TOP_H);
    end

    // Counter high read: latched byte on wide timers, zero otherwise.
    generate
        if (WIDTH > 8) begin : g_wide
            assign cnt_hi_rd = temp_q;
        end else begin : g_narrow
            assign cnt_hi_rd = 8'h00;
        end
    endgenerate

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
            top_q   <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                ADR_CTRL:   ctrl_q  <= wdata[5:0];
                ADR_CMPA_L: cmp_a_q <= wide_val;
                ADR_CMPB_L: cmp_b_q <= wide_val;
                ADR_TOP_L:  top_q   <= wide_val;
                ADR_MASK:   mask_q  <= wdata[2:0];
                default: ;
            endcase
        end
    end

    // Temporary byte: loaded by high writes, or by a counter-low read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else if (hi_wr) begin
            temp_q <= wdata;
        end else if (rd_en && addr == ADR_CNT_L) begin
            temp_q <= cnt16[15:8];
        end
    end

    // Flags: events set, written ones clear; a set wins over a clear.
    always_comb begin
        flag_clr = (wr_en && addr == ADR_FLAG) ? wdata[2:0] : 3'b000;
        flag_set = {set_cmpb, set_cmpa, set_ovf};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | flag_set;
    end

    // Read mux.
    always_comb begin
        case (addr)
            ADR_CTRL:   rdata = {2'b00, ctrl_q};
            ADR_CNT_L:  rdata = cnt16[7:0];
            ADR_CNT_H:  rdata = cnt_hi_rd;
            ADR_CMPA_L: rdata = cmpa16[7:0];
            ADR_CMPA_H: rdata = cmpa16[15:8];
            ADR_CMPB_L: rdata = cmpb16[7:0];
            ADR_CMPB_H: rdata = cmpb16[15:8];
            ADR_FLAG:   rdata = {5'b0, flag_q};
            ADR_MASK:   rdata = {5'b0, mask_q};
            ADR_TOP_L:  rdata = top16[7:0];
            ADR_TOP_H:  rdata = top16[15:8];
            default:    rdata = 8'h00;
        endcase
    end

    // Outputs towards the prescaler and the core.
    always_comb begin
        clk_sel  = ctrl_q[2:0];
        mode     = count_mode_e'(ctrl_q[5:3]);
        ctrl_wr  = wr_en && addr == ADR_CTRL;
        load     = wr_en && addr == ADR_CNT_L;
        load_val = wide_val;
        cmp_a    = cmp_a_q;
        cmp_b    = cmp_b_q;
        top_val  = top_q;
        irq_vec  = flag_q & mask_q;
    end

    // R6: writing one to the overflow flag clears it
    p_w1c_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_FLAG && wdata[0] && !set_ovf) |=> !flag_q[0]);
    // R6: writing one to the compare-A flag clears it
    p_w1c_cmpa_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_FLAG && wdata[1] && !set_cmpa) |=> !flag_q[1]);

endmodule

// File: rtl/cmp_timer.sv
// Top: prescaled timer/counter with two compare channels, write-one-to-clear
// flags and masked interrupt requests. Assumes WIDTH between 8 and 16.
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter bit ALT_DIV   = 1'b0,
    parameter int MAX_RATIO = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [3:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [WIDTH-1:0] count_o,
    output logic             irq_ovf,
    output logic             irq_cmpa,
    output logic             irq_cmpb
);
    logic [2:0]       clk_sel, irq_vec;
    count_mode_e      mode;
    logic             ctrl_wr, load, tick, set_ovf, set_cmpa, set_cmpb;
    logic [WIDTH-1:0] load_val, cmp_a, cmp_b, top_val, cnt;

    timer_regs #(.WIDTH(WIDTH)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt(cnt), .set_ovf(set_ovf),
        .set_cmpa(set_cmpa), .set_cmpb(set_cmpb), .clk_sel(clk_sel), .mode(mode),
        .ctrl_wr(ctrl_wr), .load(load), .load_val(load_val), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .top_val(top_val), .irq_vec(irq_vec)
    );

    timer_prescale #(.ALT_DIV(ALT_DIV), .MAX_RATIO(MAX_RATIO)) psc_i (
        .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .sel(clk_sel), .tick(tick)
    );

    timer_core #(.WIDTH(WIDTH)) core_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .top_val(top_val), .load(load), .load_val(load_val),
        .cnt(cnt), .set_ovf(set_ovf), .set_cmpa(set_cmpa), .set_cmpb(set_cmpb)
    );

    // Drive the count and the masked requests out.
    always_comb begin
        count_o  = cnt;
        irq_ovf  = irq_vec[0];
        irq_cmpa = irq_vec[1];
        irq_cmpb = irq_vec[2];
    end

endmodule

// File: tb/cmp_timer_tb_top.sv
// Directed bench: one task per scenario on a 16-bit standard-table timer
// (dut_i) and an 8-bit alternate-table timer (dut_alt_i).
module cmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_m = 1'b0, rd_m = 1'b0, wr_a = 1'b0, rd_a = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata_m, rdata_a;
    logic [15:0] cnt_m;
    logic [7:0]  cnt_a;
    logic        ovf_m, cma_m, cmb_m, ovf_a, cma_a, cmb_a;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_timer #(.WIDTH(16), .ALT_DIV(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_m), .rd_en(rd_m), .addr(addr),
        .wdata(wdata), .rdata(rdata_m), .count_o(cnt_m), .irq_ovf(ovf_m),
        .irq_cmpa(cma_m), .irq_cmpb(cmb_m));

    cmp_timer #(.WIDTH(8), .ALT_DIV(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .rd_en(rd_a), .addr(addr),
        .wdata(wdata), .rdata(rdata_a), .count_o(cnt_a), .irq_ovf(ovf_a),
        .irq_cmpa(cma_a), .irq_cmpb(cmb_a));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Write one register; returns at the negedge after the write edge.
    task automatic wr(input bit alt, input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d;
        if (alt) wr_a = 1'b1; else wr_m = 1'b1;
        @(negedge clk);
        wr_a = 1'b0; wr_m = 1'b0;
    endtask

    // Read one register; samples before the edge that captures rd_en.
    task automatic rd(input bit alt, input logic [3:0] a, output logic [7:0] d);
        addr = a;
        if (alt) rd_a = 1'b1; else rd_m = 1'b1;
        #1;
        d = alt ? rdata_a : rdata_m;
        @(negedge clk);
        rd_a = 1'b0; rd_m = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        do_reset();
        check("R1 count", 32'(cnt_m), 0);
        rd(0, 4'd7, d); check("R1 flags", 32'(d), 0);
        rd(0, 4'd0, d); check("R1 ctrl", 32'(d), 0);
        check("R1 irq", {ovf_m, cma_m, cmb_m}, 0);
    endtask

    task automatic t_stopped();
        do_reset();
        wr(0, 4'd0, 8'h00);
        wait_n(50);
        check("R2 stopped count", 32'(cnt_m), 0);
    endtask

    task automatic t_dividers();
        do_reset();
        wr(0, 4'd0, 8'h01);
        wait_n(5);
        check("R3 div1", 32'(cnt_m), 5);
        do_reset();
        wr(0, 4'd0, 8'h03);
        wait_n(63);
        check("R3 div64 before", 32'(cnt_m), 0);
        wait_n(1);
        check("R3 div64 step", 32'(cnt_m), 1);
    endtask

    task automatic t_alt256();
        do_reset();
        wr(1, 4'd0, 8'h06);
        wait_n(255); check("R4 edge255", 32'(cnt_a), 0);
        wait_n(1);   check("R4 edge256", 32'(cnt_a), 1);
        wait_n(255); check("R4 edge511", 32'(cnt_a), 1);
        wait_n(1);   check("R4 edge512", 32'(cnt_a), 2);
    endtask

    task automatic t_wrap_and_zero();
        logic [7:0] d;
        do_reset();
        wr(1, 4'd1, 8'hFF);
        wr(1, 4'd0, 8'h01);
        wait_n(1);
        check("R5 wrap8 count", 32'(cnt_a), 0);
        rd(1, 4'd7, d);
        check("R5 R9 wrap8 flags only ovf", 32'(d), 32'h1);
        do_reset();
        wr(1, 4'd0, 8'h09);
        wait_n(10);
        check("R9 zero cmpA count", 32'(cnt_a), 10);
        rd(1, 4'd7, d);
        check("R9 zero cmpA no flag", 32'(d), 0);
    endtask

    task automatic t_fastpwm_w1c();
        logic [7:0] d;
        do_reset();
        wr(0, 4'd8, 8'h01);
        wr(0, 4'd2, 8'hFF);
        wr(0, 4'd1, 8'hFF);
        check("R11 wide load", 32'(cnt_m), 32'hFFFF);
        wr(0, 4'd0, 8'h11);
        wait_n(1);
        check("R5 fastpwm wrap", 32'(cnt_m), 0);
        check("R6 irq raised", 32'(ovf_m), 1);
        wr(0, 4'd7, 8'h00);
        check("R6 write zero keeps", 32'(ovf_m), 1);
        wr(0, 4'd7, 8'h01);
        check("R6 w1c drops irq", 32'(ovf_m), 0);
        rd(0, 4'd7, d);
        check("R6 w1c flag", 32'(d), 0);
    endtask

    task automatic t_compare();
        logic [7:0] d;
        do_reset();
        wr(0, 4'd4, 8'h00);
        wr(0, 4'd3, 8'h10);
        wr(0, 4'd5, 8'h08);
        wr(0, 4'd0, 8'h01);
        wait_n(8);
        check("R7 count at B", 32'(cnt_m), 8);
        rd(0, 4'd7, d);
        check("R7 flag B", 32'(d), 32'h4);
        check("R6 masked irq B", 32'(cmb_m), 0);
        wait_n(7);
        rd(0, 4'd7, d);
        check("R7 flag A and B", 32'(d), 32'h6);
        wr(0, 4'd8, 8'h02);
        check("R6 mask A irq", {cma_m, cmb_m}, 2'b10);
        wr(0, 4'd7, 8'h02);
        check("R6 w1c A irq", 32'(cma_m), 0);
    endtask

    task automatic t_ctc();
        logic [7:0] d;
        do_reset();
        wr(1, 4'd3, 8'h05);
        wr(1, 4'd0, 8'h09);
        wait_n(4);
        check("R8 before match", 32'(cnt_a), 4);
        wait_n(1);
        check("R8 cleared", 32'(cnt_a), 0);
        rd(1, 4'd7, d);
        check("R8 flags ovf+A", 32'(d), 32'h3);
        check("R8 restart", 32'(cnt_a), 1);
    endtask

    task automatic t_phase();
        logic [7:0] d;
        do_reset();
        wr(1, 4'd1, 8'hFE);
        wr(1, 4'd0, 8'h19);
        wait_n(1);   check("R10 top", 32'(cnt_a), 32'hFF);
        wait_n(1);   check("R10 turn down", 32'(cnt_a), 32'hFE);
        wait_n(253); check("R10 near bottom", 32'(cnt_a), 1);
        rd(1, 4'd7, d);
        check("R10 no ovf yet", 32'(d), 0);
        check("R10 bottom", 32'(cnt_a), 0);
        wait_n(1);
        check("R10 up again", 32'(cnt_a), 1);
        rd(1, 4'd7, d);
        check("R10 ovf at bottom", 32'(d), 1);
    endtask

    task automatic t_temp_write();
        do_reset();
        wr(0, 4'd2, 8'h55);
        check("R11 high alone", 32'(cnt_m), 0);
        wr(0, 4'd1, 8'h22);
        check("R11 commit", 32'(cnt_m), 32'h5522);
    endtask

    task automatic t_temp_read();
        logic [7:0] lo, hi;
        do_reset();
        wr(0, 4'd2, 8'h12);
        wr(0, 4'd1, 8'hFE);
        wr(0, 4'd0, 8'h01);
        wait_n(1);
        check("R12 start", 32'(cnt_m), 32'h12FF);
        rd(0, 4'd1, lo);
        rd(0, 4'd2, hi);
        check("R12 low", 32'(lo), 32'hFF);
        check("R12 latched high", 32'(hi), 32'h12);
        check("R12 live high moved", 32'(cnt_m[15:8]), 32'h13);
    endtask

    task automatic t_top_mode();
        logic [7:0] d;
        do_reset();
        wr(0, 4'd10, 8'h00);
        wr(0, 4'd9, 8'h10);
        wr(0, 4'd2, 8'h00);
        wr(0, 4'd1, 8'h0E);
        wr(0, 4'd0, 8'h21);
        wait_n(2);
        check("R13 at top", 32'(cnt_m), 32'h10);
        wait_n(1);
        check("R13 wrapped", 32'(cnt_m), 0);
        rd(0, 4'd7, d);
        check("R13 no ovf", 32'(d), 0);
    endtask

    task automatic t_priority();
        do_reset();
        wr(0, 4'd0, 8'h01);
        wait_n(3);
        check("R14 running", 32'(cnt_m), 3);
        wr(0, 4'd1, 8'h40);
        check("R14 write wins", 32'(cnt_m), 32'h40);
        wait_n(1);
        check("R14 resumes", 32'(cnt_m), 32'h41);
    endtask

    initial begin
        t_reset_state();
        t_stopped();
        t_dividers();
        t_alt256();
        t_wrap_and_zero();
        t_fastpwm_w1c();
        t_compare();
        t_ctc();
        t_phase();
        t_temp_write();
        t_temp_read();
        t_top_mode();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule